// File: doc/BRIEF.md
# Status flag and condition unit

This block sits behind the arithmetic datapath. It receives the result of an add, a subtract or a logical operation, together with the adder's carry or borrow output and the sign bits of both operands. From these it derives four status flags: negative, zero, carry and signed overflow. It keeps the flags in the four most significant bits of a status word.

A 4-bit condition code is tested against the stored flags at all times. The result drives an execute-enable that tells the pipeline whether the current conditional instruction may commit. The flags change only on a clock edge at which the set-flags enable is high. The condition evaluation therefore always sees the flags left behind by the last flag-setting instruction.

Top module: `status_cond_unit`

## Requirements
- R1: On a clock edge with set_flags_i high, the negative flag (flags_o[3], status bit STAT_W-1) takes bit DATA_W-1 of result_i.
- R2: On a clock edge with set_flags_i high, the zero flag (flags_o[2], status bit STAT_W-2) is set exactly when every bit of result_i is zero.
- R3: For op_i = 2'b00 (add), a flag update loads the carry flag (flags_o[1], status bit STAT_W-3) with carry_i, which is the unsigned carry-out.
- R4: For op_i = 2'b01 (subtract), carry_i is the borrow-out, and a flag update loads the carry flag with its inverse: 1 means no borrow.
- R5: A flag update loads the overflow flag (flags_o[0], status bit STAT_W-4) as follows. For add, it is 1 when both operand signs match and the result sign differs from them. For subtract, it is 1 when the operand signs differ and the result sign differs from opa_sign_i. It is 0 otherwise.
- R6: status_o holds the flags in its top four bits, in the order N, Z, C, V from the MSB down, and all of its lower bits are zero.
- R7: While set_flags_i is low, all four flags keep their values across clock edges, whatever the other inputs do.
- R8: For op_i = 2'b10 or 2'b11 (logical), a flag update sets N and Z from the result and keeps C and V at their previous values. carry_i and the operand signs have no effect.
- R9: exec_en_o is a combinational function of cond_i and the stored flags. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R10: cond_i = 14 always gives exec_en_o = 1, and cond_i = 15 always gives exec_en_o = 0.
- R11: An active-low asynchronous reset clears all four flags, so status_o reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation class: 00 add, 01 subtract, 10/11 logical |
| opa_sign_i | input | 1 | Sign bit of the first operand |
| opb_sign_i | input | 1 | Sign bit of the second operand |
| result_i | input | DATA_W | Result produced by the datapath |
| carry_i | input | 1 | Carry-out for add, borrow-out for subtract |
| set_flags_i | input | 1 | Load the new flags at this clock edge |
| cond_i | input | 4 | Condition code under test |
| flags_o | output | 4 | Stored flags {N, Z, C, V} |
| status_o | output | STAT_W | Status word with the flags in its top four bits |
| exec_en_o | output | 1 | The condition holds, so the instruction commits |

## Verification
The bench builds the unit with DATA_W = 32, STAT_W = 32 and ZCHUNK_W = 8. This width lets the vectors place single set bits at the extremes of the result (bits 0 and 31), which exercises the chunked zero detector at both of its ends. It also lets them drive the sign transitions at 0x7FFFFFFF and 0x80000000. A flag-sweep phase builds every reachable flag combination through the add path and then walks all sixteen condition codes against each one. With the default status width, the fixed flag positions at bits 31 to 28 are directly visible.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_SUB    = 2'b01,
    OP_LOGIC  = 2'b10,
    OP_LOGIC2 = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // bit 0 of the code inverts the pair's base test
  typedef enum logic [2:0] {
    CP_ZERO  = 3'd0,
    CP_CARRY = 3'd1,
    CP_NEG   = 3'd2,
    CP_OVF   = 3'd3,
    CP_UHI   = 3'd4,
    CP_SGE   = 3'd5,
    CP_SGT   = 3'd6,
    CP_ALL   = 3'd7
  } cond_pair_e;
endpackage

// File: rtl/scu_flag_gen.sv
module scu_flag_gen
  import scu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ZCHUNK_W = 8
) (
  input  alu_op_e           op_i,
  input  logic              opa_sign_i,
  input  logic              opb_sign_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  flags_t            cur_i,
  output flags_t            nxt_o
);
  localparam int NCHUNK = DATA_W / ZCHUNK_W;

  logic [NCHUNK-1:0] chunk_nz;
  logic              res_zero;
  logic              res_sign;
  logic              ovf_add;
  logic              ovf_sub;

  // zero detect split into chunks to keep the OR tree shallow
  for (genvar g = 0; g < NCHUNK; g++) begin : g_zchunk
    assign chunk_nz[g] = |result_i[g*ZCHUNK_W +: ZCHUNK_W];
  end

  assign res_zero = ~|chunk_nz;
  assign res_sign = result_i[DATA_W-1];
  assign ovf_add  = (opa_sign_i == opb_sign_i) && (res_sign != opa_sign_i);
  assign ovf_sub  = (opa_sign_i != opb_sign_i) && (res_sign != opa_sign_i);

  always_comb begin
    nxt_o.n = res_sign;
    nxt_o.z = res_zero;
    unique case (op_i)
      OP_ADD: begin
        nxt_o.c = carry_i;
        nxt_o.v = ovf_add;
      end
      OP_SUB: begin
        nxt_o.c = ~carry_i;
        nxt_o.v = ovf_sub;
      end
      default: begin
        nxt_o.c = cur_i.c;
        nxt_o.v = cur_i.v;
      end
    endcase
  end
endmodule

// File: rtl/scu_flag_reg.sv
module scu_flag_reg
  import scu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t nxt_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= nxt_i;
    end
  end
endmodule

// File: rtl/scu_cond_eval.sv
module scu_cond_eval
  import scu_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_i,
  output logic       exec_o
);
  cond_pair_e pair;
  logic       base;

  assign pair = cond_pair_e'(cond_i[3:1]);

  always_comb begin
    unique case (pair)
      CP_ZERO:  base = flags_i.z;
      CP_CARRY: base = flags_i.c;
      CP_NEG:   base = flags_i.n;
      CP_OVF:   base = flags_i.v;
      CP_UHI:   base = flags_i.c & ~flags_i.z;
      CP_SGE:   base = (flags_i.n == flags_i.v);
      CP_SGT:   base = ~flags_i.z & (flags_i.n == flags_i.v);
      default:  base = 1'b1;
    endcase
  end

  assign exec_o = base ^ cond_i[0];
endmodule

// File: rtl/status_cond_unit.sv
module status_cond_unit
  import scu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 32,
  parameter int ZCHUNK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              opa_sign_i,
  input  logic              opb_sign_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              set_flags_i,
  input  logic [3:0]        cond_i,
  output logic [3:0]        flags_o,
  output logic [STAT_W-1:0] status_o,
  output logic              exec_en_o
);
  localparam int LOW_W = STAT_W - FLAG_W;

  flags_t flags_q;
  flags_t flags_nxt;

  scu_flag_gen #(
    .DATA_W  (DATA_W),
    .ZCHUNK_W(ZCHUNK_W)
  ) u_gen (
    .op_i      (alu_op_e'(op_i)),
    .opa_sign_i(opa_sign_i),
    .opb_sign_i(opb_sign_i),
    .result_i  (result_i),
    .carry_i   (carry_i),
    .cur_i     (flags_q),
    .nxt_o     (flags_nxt)
  );

  scu_flag_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(set_flags_i),
    .nxt_i (flags_nxt),
    .q_o   (flags_q)
  );

  scu_cond_eval u_cond (
    .flags_i(flags_q),
    .cond_i (cond_i),
    .exec_o (exec_en_o)
  );

  assign flags_o  = flags_q;
  assign status_o = {flags_q, {LOW_W{1'b0}}};
endmodule

// File: rtl/status_cond_unit_chk.sv
module status_cond_unit_chk #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_i,
  input logic              opa_sign_i,
  input logic              opb_sign_i,
  input logic [DATA_W-1:0] result_i,
  input logic              carry_i,
  input logic              set_flags_i,
  input logic [3:0]        cond_i,
  input logic [3:0]        flags_o,
  input logic [STAT_W-1:0] status_o,
  input logic              exec_en_o
);
  // R1
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> flags_o[3] == $past(result_i[DATA_W-1]));

  // R2
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> flags_o[2] == ($past(result_i) == '0));

  // R3
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i == 2'b00) |=> flags_o[1] == $past(carry_i));

  // R4
  sub_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i == 2'b01) |=> flags_o[1] != $past(carry_i));

  // R5
  add_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i == 2'b00 && opa_sign_i != opb_sign_i) |=> !flags_o[0]);

  // R6
  status_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STAT_W-1 -: 4] == flags_o && status_o[STAT_W-5:0] == '0);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_flags_i |=> $stable(flags_o));

  // R8
  logic_cv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flags_i && op_i[1]) |=> flags_o[1:0] == $past(flags_o[1:0]));

  // R9
  eq_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'd0 |-> exec_en_o == flags_o[2]);

  // R10
  always_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'd14 |-> exec_en_o);

  // R10
  never_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'd15 |-> !exec_en_o);
endmodule

bind status_cond_unit status_cond_unit_chk #(
  .DATA_W(DATA_W),
  .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/status_cond_unit_bench.sv
`timescale 1ns/1ps
module status_cond_unit_bench;
  localparam int DATA_W = 32;
  localparam int STAT_W = 32;
  localparam int NVEC   = 10;

  // {op[1:0], sa, sb, carry, result[31:0], exp NZCV}
  localparam logic [40:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_0005, 4'b0000},
    {2'b00, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 4'b1001},
    {2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 4'b0111},
    {2'b01, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 4'b0110},
    {2'b01, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1000},
    {2'b01, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 4'b1001},
    {2'b10, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 4'b0101},
    {2'b00, 1'b1, 1'b0, 1'b1, 32'h7FFF_FFFF, 4'b0010},
    {2'b11, 1'b1, 1'b1, 1'b0, 32'h8000_0001, 4'b1010},
    {2'b01, 1'b1, 1'b0, 1'b0, 32'h7000_0000, 4'b0011}
  };

  logic              clk;
  logic              rst_n;
  logic [1:0]        op;
  logic              sa, sb, cy, set_f;
  logic [DATA_W-1:0] res;
  logic [3:0]        cond;
  logic [3:0]        flags;
  logic [STAT_W-1:0] status;
  logic              exec_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  status_cond_unit #(.DATA_W(DATA_W), .STAT_W(STAT_W), .ZCHUNK_W(8)) u_status_cond_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_sign_i(sa), .opb_sign_i(sb),
    .result_i(res), .carry_i(cy), .set_flags_i(set_f), .cond_i(cond),
    .flags_o(flags), .status_o(status), .exec_en_o(exec_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [STAT_W-1:0] act, input logic [STAT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_model(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cc, v, b;
    {n, z, cc, v} = f;
    case (c[3:1])
      3'd0: b = z;
      3'd1: b = cc;
      3'd2: b = n;
      3'd3: b = v;
      3'd4: b = cc & ~z;
      3'd5: b = (n == v);
      3'd6: b = ~z & (n == v);
      default: b = 1'b1;
    endcase
    return b ^ c[0];
  endfunction

  task automatic step(input logic [1:0] o, input logic a, input logic b, input logic c,
                      input logic [DATA_W-1:0] r, input logic s);
    @(negedge clk);
    op = o; sa = a; sb = b; cy = c; res = r; set_f = s;
    @(posedge clk);
    #1;
    set_f = 1'b0;
  endtask

  initial begin
    op = 2'b00; sa = 0; sb = 0; cy = 0; res = '0; set_f = 0; cond = 4'd14;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset flags", {28'h0, flags}, '0);
    check("R11 reset status", status, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table: R1 R2 R3 R4 R5 R8 R6
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][40:39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:4], 1'b1);
      check($sformatf("R1/R2/R3/R4/R5/R8 vec %0d", i), {28'h0, flags}, {28'h0, VEC[i][3:0]});
      check($sformatf("R6 status vec %0d", i), status, {VEC[i][3:0], 28'h0});
    end

    // R7: disabled update leaves flags (0011) untouched
    step(2'b00, 1'b1, 1'b1, 1'b1, 32'h8000_0000, 1'b0);
    check("R7 hold after add", {28'h0, flags}, 32'h3);
    step(2'b01, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0);
    check("R7 hold after sub", {28'h0, flags}, 32'h3);

    // R2 single set bits at the ends of the result
    step(2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 1'b1);
    check("R2 lsb set not zero", {28'h0, flags}, 32'h3);
    step(2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 1'b1);
    check("R2 chunk edge not zero", {28'h0, flags}, 32'h3);

    // R9 R10: sweep conditions over reachable flag combinations
    for (int f = 0; f < 16; f++) begin
      logic fn, fz, fc, fv;
      logic [DATA_W-1:0] r;
      {fn, fz, fc, fv} = f[3:0];
      if (fn && fz) continue;
      r = fz ? 32'h0 : (fn ? 32'h8000_0010 : 32'h0000_0010);
      step(2'b00, fv ? ~fn : fn, fv ? ~fn : fn, fc, r, 1'b1);
      check($sformatf("R1/R3/R5 setup %0d", f), {28'h0, flags}, {28'h0, f[3:0]});
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        cond = c[3:0];
        #1;
        check($sformatf("R9/R10 flags=%b cond=%0d", f[3:0], c), {31'h0, exec_en},
              {31'h0, cond_model(f[3:0], c[3:0])});
      end
    end

    // R11 asynchronous reset in mid-run
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R11 async clear", {28'h0, flags}, '0);
    check("R10 never after reset", {31'h0, exec_en}, {31'h0, cond_model(4'h0, cond)});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule